// File: doc/BRIEF.md
# AES-128 Round Key Table Builder

This block expands a 128-bit AES cipher key into the full schedule of eleven 128-bit keys. A one-cycle `start` pulse captures the key into table slot 0. On each of the following ten clocks, the block derives the next round key from the one before it and writes it into the next slot. When slot 10 has been written, `done` rises and stays high.

The table has one combinational read port addressed by `rd_addr`. A decryption core can fetch the keys in any order, including last round first, with no latency. Only the key schedule is built here; the cipher datapath is not.

Byte order is big-endian. Bits [127:96] form word 0. Within a word, bits [31:24] are row 0.

Top module: `aes128_key_table`

## Requirements
- R1: After reset, `done` is 0 and every table address reads as all zeros.
- R2: The clock edge that samples `start` high writes `key_in` into slot 0 (read with `rd_addr`=0).
- R3: Slot i (1 to 10) holds the following, where wj is word j of slot i-1 and T = SubWord(RotWord(w3)) XOR ({Rcon(i), 24'h0}):
  - word 0 = w0 ^ T
  - word 1 = w1 ^ word 0
  - word 2 = w2 ^ word 1
  - word 3 = w3 ^ word 2
- R4: RotWord moves each byte up one row (row 1 to row 0, and row 0 to row 3). SubWord applies the forward AES S-box to each byte.
- R5: Rcon(1..10) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. For the key 2b7e151628aed2a6abf7158809cf4f3c, slot 10 reads d014f9a8c9ee2589e13f0cc8b6630ca6.
- R6: `done` rises on the 11th rising clock edge counted from the edge that samples `start`, and is 0 before that edge.
- R7: `done` stays 1 until the next `start`. The edge that samples `start` clears it.
- R8: `rd_key` follows `rd_addr` in the same cycle. Addresses 11 to 15 read as all zeros.
- R9: A `start` during generation abandons the run in progress and begins again from the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins an expansion |
| key_in | input | 128 | Cipher key, sampled with `start` |
| rd_addr | input | 4 | Table read address |
| rd_key | output | 128 | Key stored at `rd_addr` |
| done | output | 1 | High once all 11 slots are written |

## Verification
The bench targets the following corner cases:
- **Rcon wraps past 80 to 1B.** A design that only doubled the constant would corrupt slots 9 and 10. The published test key exposes this through its last round key.
- **Rotation direction.** Random keys catch a design that rotated the wrong way, or that fed a column other than the last one into the S-box.
- **Timing of `done`.** It is probed one cycle before and one cycle at the expected edge, which catches an off-by-one counter.
- **Restart mid-run.** A second `start` partway through must leave a table built only from the new key. A design that kept its old counter or constant would fail this.
- **Unused addresses.** Addresses 11 to 15 must read zero.

// File: rtl/aes128_key_table.sv
module aes128_key_table (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] key_in,
  input  logic [3:0]   rd_addr,
  output logic [127:0] rd_key,
  output logic         done
);
  localparam int NSLOT = 11;
  localparam logic [3:0] LAST = 4'(NSLOT - 1);

  logic [127:0] tbl [NSLOT];
  logic [127:0] prev, nxt;
  logic [3:0]   cnt;
  logic         busy;
  logic [7:0]   rcon;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p = 8'h00; aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xt(aa);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] r, sq, s;
    r = 8'h01; sq = x;
    for (int k = 1; k < 8; k++) begin
      sq = gmul(sq, sq);
      r  = gmul(r, sq);
    end
    s = 8'h63;
    for (int j = 0; j < 8; j++)
      s[j] = s[j] ^ r[j] ^ r[(j+4)%8] ^ r[(j+5)%8] ^ r[(j+6)%8] ^ r[(j+7)%8];
    return s;
  endfunction

  logic [31:0] w0, w1, w2, w3, rot, t, n0, n1, n2, n3;
  assign {w0, w1, w2, w3} = prev;
  assign rot = {w3[23:0], w3[31:24]};
  assign t   = {sbox(rot[31:24]), sbox(rot[23:16]), sbox(rot[15:8]), sbox(rot[7:0])}
               ^ {rcon, 24'h0};
  assign n0  = w0 ^ t;
  assign n1  = w1 ^ n0;
  assign n2  = w2 ^ n1;
  assign n3  = w3 ^ n2;
  assign nxt = {n0, n1, n2, n3};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) tbl[i] <= '0;
      prev <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      rcon <= 8'h01;
    end else if (start) begin
      tbl[0] <= key_in;
      prev   <= key_in;
      cnt    <= 4'd1;
      rcon   <= 8'h01;
      busy   <= 1'b1;
      done   <= 1'b0;
    end else if (busy) begin
      tbl[cnt] <= nxt;
      prev     <= nxt;
      rcon     <= xt(rcon);
      cnt      <= cnt + 4'd1;
      if (cnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign rd_key = (rd_addr <= LAST) ? tbl[rd_addr] : '0;

  a_r2_slot0_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tbl[0] == $past(key_in));
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == LAST && !start |=> done && !busy);
  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr > LAST |-> rd_key == '0);
endmodule

// File: tb/aes128_key_table_bench.sv
module aes128_key_table_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [127:0] key_in = '0;
  logic [3:0] rd_addr = '0;
  logic [127:0] rd_key;
  logic done;
  int total = 0, bad = 0;
  logic [127:0] ref_tbl [11];

  always #2 clk = ~clk;

  aes128_key_table u_aes128_key_table (.clk(clk), .rst_n(rst_n), .start(start),
    .key_in(key_in), .rd_addr(rd_addr), .rd_key(rd_key), .done(done));

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung (actual=timeout expected=finish)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h00, s;
    for (int b = 1; b < 256; b++) if (m_mul(a, 8'(b)) == 8'h01) inv = 8'(b);
    s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
        ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return s;
  endfunction

  function automatic logic [7:0] m_rcon(input int i);
    case (i)
      1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
      5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
      9: return 8'h1b; default: return 8'h36;
    endcase
  endfunction

  task automatic build_ref(input logic [127:0] k);
    logic [31:0] w [44];
    for (int j = 0; j < 4; j++) w[j] = k[127-32*j -: 32];
    for (int j = 4; j < 44; j++) begin
      if (j % 4 == 0) begin
        logic [31:0] r;
        r = {w[j-1][23:0], w[j-1][31:24]};
        r = {m_sbox(r[31:24]), m_sbox(r[23:16]), m_sbox(r[15:8]), m_sbox(r[7:0])};
        w[j] = w[j-4] ^ r ^ {m_rcon(j/4), 24'h0};
      end else w[j] = w[j-4] ^ w[j-1];
    end
    for (int i = 0; i < 11; i++) ref_tbl[i] = {w[4*i], w[4*i+1], w[4*i+2], w[4*i+3]};
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [127:0] k);
    @(negedge clk); key_in = k; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_table(input string req);
    for (int a = 0; a < 11; a++) begin
      rd_addr = 4'(a); #0.5;
      chk(req, rd_key, ref_tbl[a]);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 done", 128'(done), 128'd0);
    for (int a = 0; a < 16; a += 5) begin
      rd_addr = 4'(a); #0.5; chk("R1 zero table", rd_key, '0);
    end
    rst_n = 1'b1;

    // R5 and R6: published key, done timing
    build_ref(128'h2b7e151628aed2a6abf7158809cf4f3c);
    kick(128'h2b7e151628aed2a6abf7158809cf4f3c);
    rd_addr = 4'd0; #0.5; chk("R2 slot0", rd_key, ref_tbl[0]);
    repeat (9) @(negedge clk);
    chk("R6 done early", 128'(done), 128'd0);
    @(negedge clk);
    chk("R6 done on edge 11", 128'(done), 128'd1);
    rd_addr = 4'd10; #0.5;
    chk("R5 known round 10", rd_key, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    rd_addr = 4'd1; #0.5;
    chk("R4 known round 1", rd_key, 128'ha0fafe1788542cb123a339392a6c7605);
    check_table("R3 known key");
    repeat (5) @(negedge clk);
    chk("R7 done holds", 128'(done), 128'd1);
    for (int a = 11; a < 16; a++) begin
      rd_addr = 4'(a); #0.5; chk("R8 unused addr", rd_key, '0);
    end

    // R3 and R4: random keys
    for (int n = 0; n < 6; n++) begin
      logic [127:0] k;
      k = {$urandom, $urandom, $urandom, $urandom};
      build_ref(k);
      kick(k);
      chk("R7 start clears", 128'(done), 128'd0);
      repeat (10) @(negedge clk);
      chk("R6 done random", 128'(done), 128'd1);
      check_table("R3 random key");
    end

    // R9: restart mid-run
    kick(128'h00112233445566778899aabbccddeeff);
    repeat (4) @(negedge clk);
    build_ref(128'hffffffffffffffffffffffffffffffff);
    kick(128'hffffffffffffffffffffffffffffffff);
    repeat (9) @(negedge clk);
    chk("R9 no done early", 128'(done), 128'd0);
    @(negedge clk);
    chk("R9 done after restart", 128'(done), 128'd1);
    check_table("R9 restart table");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule